// File: doc/BRIEF.md
# ADC Result and Interrupt Registers

This block is the register side of a five-channel analog-to-digital converter. An abstract converter reports each finished conversion with a one-cycle strobe, a channel number and a 10-bit result. The block stores the result in that channel's data register, raises a completion flag, and raises an overrun flag in burst mode when an unread result is overwritten. Both flags clear when software reads the register. A global data register mirrors the latest result and its channel number, and has its own completion flag.

An interrupt line combines the per-channel completion flags with their enable bits, and the global completion flag with its own enable. In single-conversion mode, a start code selects one of six hardware trigger inputs. Each trigger is synchronised through two flip-flops, and a control bit chooses whether a rising or a falling edge requests a conversion. The request goes to the converter as a one-cycle start pulse with a channel number taken from the control register.

The bus is a simple word-addressed read/write port. A read takes effect in the cycle where `bus_sel` is high and `bus_wr` is low. Read data is combinational, and clear-on-read side effects land on the clock edge that ends the access.

Top module: `adc_result_regs`

## Requirements
- R1: Word addresses are: 0 control, 1 global data, 2 interrupt enable, 4+k data of channel k (k = 0..4). Control bits are [2:0] start code, [3] burst, [4] falling-edge select and [7:5] start channel, and it resets to 0. Interrupt enable holds channel enables in [4:0] and the global enable in [8], and resets to 0x100. All other bits of these two registers read as zero.
- R2: A channel data word holds the result in bits 15:6, the overrun flag in bit 30 and the done flag in bit 31. Bits 5:0 and 29:16 always read as zero.
- R3: A completion on channel k sets that channel's done flag and stores the result, visible from the next cycle. A read of that channel's register clears done and keeps the result.
- R4: Overrun of channel k is set only when a completion arrives on k while burst (control bit 3) is 1 and k's done flag is already set. It clears when k's register is read. In single mode a second unread completion leaves overrun at 0.
- R5: When a completion and a read of the same register fall in one cycle, the flag is left set and the read returns the previous contents. The new result is stored.
- R6: The global data word holds the latest result in bits 15:6, its channel number in bits 26:24 and the global done flag in bit 31. Reading it clears only the global done flag. Reading a channel register leaves global done untouched.
- R7: `irq` is high when any channel has both its done flag and its enable set, or when global done and the global enable are both set. Otherwise it is low.
- R8: With burst 0 and a start code c of 2..7, the selected edge on `trig_in[c-2]` (rising when bit 4 is 0, falling when it is 1) produces a one-cycle `start_req`. The pulse is observed after the second rising clock edge that follows the input change. `start_chan` equals control bits [7:5].
- R9: No `start_req` is produced while burst is 1, for start codes 0 and 1, or for edges on the unselected inputs or of the opposite polarity.
- R10: A completion carrying a channel number of 5 or above changes no register and no flag. Bus writes to data registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 9 | Write data (no writable bit lies above bit 8) |
| bus_rdata | output | 32 | Combinational read data |
| done_vld | input | 1 | Conversion-complete strobe |
| done_chan | input | 3 | Channel of the finished conversion |
| done_res | input | 10 | Conversion result |
| trig_in | input | 6 | Asynchronous hardware trigger inputs |
| start_req | output | 1 | One-cycle conversion start request |
| start_chan | output | 3 | Channel to convert |
| irq | output | 1 | Interrupt request |

## Verification
Flags, stored results and `irq` change on the clock edge that takes the completion strobe or the read. The bench drives every strobe at a falling edge, releases it at the next falling edge, and reads back only after that. Read data is sampled 1 ns after the falling edge that starts the access, which is before the clearing edge. A trigger change reaches `start_req` after two rising edges and is gone after the third. The bench samples at each of the four falling edges after the change and expects the pulse at exactly the second one. The register sweep covers every channel with extreme and mixed result values. The trigger sweep covers every start code, both polarities and every input line.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
  localparam int RES_W    = 10;
  localparam int RES_LSB  = 6;
  localparam int CHN_W    = 3;
  localparam int CHN_LSB  = 24;
  localparam int CODE_W   = 3;
  localparam int TRIG_N   = (1 << CODE_W) - 2;
  localparam int DONE_BIT = 31;
  localparam int OVR_BIT  = 30;
  localparam int GIEN_BIT = 8;
  localparam int WR_W     = GIEN_BIT + 1;

  typedef struct packed {
    logic [CHN_W-1:0]  start_ch;
    logic              fall_edge;
    logic              burst;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  function automatic logic [31:0] chan_word(logic done, logic ovr, logic [RES_W-1:0] res);
    logic [31:0] w;
    w = '0;
    w[DONE_BIT] = done;
    w[OVR_BIT]  = ovr;
    w[RES_LSB +: RES_W] = res;
    return w;
  endfunction

  function automatic logic [31:0] global_word(logic done, logic [CHN_W-1:0] chn,
                                              logic [RES_W-1:0] res);
    logic [31:0] w;
    w = '0;
    w[DONE_BIT] = done;
    w[CHN_LSB +: CHN_W] = chn;
    w[RES_LSB +: RES_W] = res;
    return w;
  endfunction

  function automatic logic edge_seen(logic prev, logic cur, logic fall);
    return fall ? (prev & ~cur) : (~prev & cur);
  endfunction
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
  parameter int TRIG_N      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_N-1:0] trig_in,
  input  logic              fall_sel,
  output logic [TRIG_N-1:0] edge_vec
);
  import adc_regs_pkg::*;

  logic [TRIG_N-1:0] stg [SYNC_STAGES];
  logic [TRIG_N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= trig_in;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      prev_q <= stg[SYNC_STAGES-1];
    end
  end

  always_comb begin
    for (int j = 0; j < TRIG_N; j++)
      edge_vec[j] = edge_seen(prev_q[j], stg[SYNC_STAGES-1][j], fall_sel);
  end
endmodule

// File: rtl/adc_chan_flags.sv
module adc_chan_flags #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpl,
  input  logic             rd_clr,
  input  logic             burst_on,
  input  logic [RES_W-1:0] res_in,
  output logic             done_q,
  output logic             ovr_q,
  output logic [RES_W-1:0] res_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      res_q  <= '0;
    end else if (cmpl) begin
      res_q  <= res_in;
      done_q <= 1'b1;
      ovr_q  <= ovr_q | (burst_on & done_q);
    end else if (rd_clr) begin
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_regs_pkg::*;
#(
  parameter int NUM_CH      = 5,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WR_W-1:0]   bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              done_vld,
  input  logic [CHN_W-1:0]  done_chan,
  input  logic [RES_W-1:0]  done_res,
  input  logic [TRIG_N-1:0] trig_in,
  output logic              start_req,
  output logic [CHN_W-1:0]  start_chan,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_GLOB = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(2);
  localparam int CH_BASE = 4;
  localparam int CTRL_W  = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [NUM_CH-1:0] ien_ch;
  logic              gien;
  logic              wr_stb, rd_stb, glob_rd;

  logic [NUM_CH-1:0] cmpl_vec, ch_rd, ch_done, ch_ovr;
  logic [RES_W-1:0]  ch_res [NUM_CH];
  logic              cmpl_ok;

  logic              gdone;
  logic [CHN_W-1:0]  gchn;
  logic [RES_W-1:0]  gres;

  logic [TRIG_N-1:0] edge_vec;
  logic              sel_edge;

  assign wr_stb  = bus_sel & bus_wr;
  assign rd_stb  = bus_sel & ~bus_wr;
  assign glob_rd = rd_stb && (bus_addr == A_GLOB);

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_ch <= '0;
      gien   <= 1'b1;
    end else if (wr_stb) begin
      if (bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (bus_addr == A_IEN) begin
        ien_ch <= bus_wdata[NUM_CH-1:0];
        gien   <= bus_wdata[GIEN_BIT];
      end
    end
  end

  // per-channel result registers
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    assign cmpl_vec[k] = done_vld && (done_chan == CHN_W'(k));
    assign ch_rd[k]    = rd_stb && (bus_addr == ADDR_W'(CH_BASE + k));
    adc_chan_flags #(.RES_W(RES_W)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmpl    (cmpl_vec[k]),
      .rd_clr  (ch_rd[k]),
      .burst_on(ctrl_q.burst),
      .res_in  (done_res),
      .done_q  (ch_done[k]),
      .ovr_q   (ch_ovr[k]),
      .res_q   (ch_res[k])
    );
  end

  assign cmpl_ok = |cmpl_vec;

  // global mirror
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gdone <= 1'b0;
      gchn  <= '0;
      gres  <= '0;
    end else if (cmpl_ok) begin
      gdone <= 1'b1;
      gchn  <= done_chan;
      gres  <= done_res;
    end else if (glob_rd) begin
      gdone <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata[CTRL_W-1:0] = ctrl_q;
    if (bus_addr == A_GLOB) bus_rdata = global_word(gdone, gchn, gres);
    if (bus_addr == A_IEN) begin
      bus_rdata[NUM_CH-1:0] = ien_ch;
      bus_rdata[GIEN_BIT]   = gien;
    end
    for (int k = 0; k < NUM_CH; k++)
      if (bus_addr == ADDR_W'(CH_BASE + k))
        bus_rdata = chan_word(ch_done[k], ch_ovr[k], ch_res[k]);
  end

  assign irq = (|(ch_done & ien_ch)) | (gien & gdone);

  // hardware trigger
  adc_trig_edge #(.TRIG_N(TRIG_N), .SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .fall_sel(ctrl_q.fall_edge),
    .edge_vec(edge_vec)
  );

  always_comb begin
    sel_edge = 1'b0;
    for (int j = 0; j < TRIG_N; j++)
      if (ctrl_q.code == CODE_W'(j + 2)) sel_edge = edge_vec[j];
  end

  assign start_req  = ~ctrl_q.burst & sel_edge;
  assign start_chan = ctrl_q.start_ch;
endmodule

// File: rtl/adc_result_regs_chk.sv
module adc_result_regs_chk
  import adc_regs_pkg::*;
#(
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              burst_on,
  input logic [CODE_W-1:0] code,
  input logic [NUM_CH-1:0] ien_ch,
  input logic              gien,
  input logic              irq,
  input logic              start_req,
  input logic [NUM_CH-1:0] cmpl_vec,
  input logic [NUM_CH-1:0] ch_rd,
  input logic [NUM_CH-1:0] ch_done,
  input logic [NUM_CH-1:0] ch_ovr
);
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_vec != '0) |=> ((ch_done & $past(cmpl_vec)) == $past(cmpl_vec))); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_rd & ~cmpl_vec) != '0) |=> ((ch_done & $past(ch_rd & ~cmpl_vec)) == '0)); // R3

  AST_OVR_BURST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_on |=> ((ch_ovr & ~$past(ch_ovr)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_rd & cmpl_vec) != '0) |=> ((ch_done & $past(ch_rd & cmpl_vec)) == $past(ch_rd & cmpl_vec))); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_ch == '0 && !gien) |-> !irq); // R7

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> (!burst_on && code >= CODE_W'(2))); // R9
endmodule

bind adc_result_regs adc_result_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .burst_on (ctrl_q.burst),
  .code     (ctrl_q.code),
  .ien_ch   (ien_ch),
  .gien     (gien),
  .irq      (irq),
  .start_req(start_req),
  .cmpl_vec (cmpl_vec),
  .ch_rd    (ch_rd),
  .ch_done  (ch_done),
  .ch_ovr   (ch_ovr)
);

// File: tb/adc_result_regs_test.sv
`timescale 1ns/1ps
module adc_result_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [8:0]  bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        done_vld = 1'b0;
  logic [2:0]  done_chan = '0;
  logic [9:0]  done_res = '0;
  logic [5:0]  trig_in = '0;
  logic        start_req;
  logic [2:0]  start_chan;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  always #4 clk = ~clk;

  adc_result_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .done_vld(done_vld), .done_chan(done_chan), .done_res(done_res),
    .trig_in(trig_in), .start_req(start_req), .start_chan(start_chan), .irq(irq)
  );

  // expected word arithmetic: done*2^31 + ovr*2^30 + res*64
  function automatic logic [31:0] exp_ch(int done, int ovr, int res);
    return 32'(done) * 32'h8000_0000 + 32'(ovr) * 32'h4000_0000 + 32'(res) * 32'd64;
  endfunction
  function automatic logic [31:0] exp_gl(int done, int chn, int res);
    return 32'(done) * 32'h8000_0000 + 32'(chn) * 32'h0100_0000 + 32'(res) * 32'd64;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int addr, logic [8:0] data);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 4'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 4'(addr);
    #1 data = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_cmpl(int ch, int res);
    @(negedge clk);
    done_vld = 1; done_chan = 3'(ch); done_res = 10'(res);
    @(negedge clk);
    done_vld = 0;
    #1;
  endtask

  task automatic clear_all();
    logic [31:0] d;
    for (int k = 0; k < 5; k++) rd(4 + k, d);
    rd(1, d);
  endtask

  task automatic trig_trial(int code, int fall, int burst, int line, bit expect_pulse);
    int sch;
    logic [5:0] idle;
    sch = (code + line) % 5;
    wr(0, 9'(code + burst * 8 + fall * 16 + sch * 32));
    idle = fall ? 6'h3F : 6'h00;
    @(negedge clk);
    trig_in = idle;
    repeat (4) @(negedge clk);
    trig_in[line] = ~idle[line];
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      #1;
      if (expect_pulse) begin
        check("R8 start pulse", 32'(start_req), 32'(i == 2));
        if (i == 2) check("R8 start_chan", 32'(start_chan), 32'(sch));
      end else begin
        check("R9 no start", 32'(start_req), 32'd0);
      end
    end
    trig_in[line] = idle[line];
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      #1 check("R9 opposite edge", 32'(start_req), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!reported) begin
      failures++;
      $display("FAIL watchdog expired");
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // reset state
    check("R7 irq reset", 32'(irq), 0);
    check("R8 start reset", 32'(start_req), 0);
    rd(0, d); check("R1 ctrl reset", d, 0);
    rd(2, d); check("R1 inten reset", d, 32'h100);
    rd(4, d); check("R2 ch0 reset", d, 0);
    rd(1, d); check("R6 global reset", d, 0);

    // R1 writable bits
    wr(2, 9'h1FF); rd(2, d); check("R1 inten bits", d, 32'h11F);
    wr(0, 9'h1FF); rd(0, d); check("R1 ctrl bits", d, 32'hFF);
    rd(3, d); check("R1 unused addr", d, 0);
    wr(0, 0); wr(2, 0);

    // R2 R3 R6 sweep
    for (int ch = 0; ch < 5; ch++) begin
      for (int p = 0; p < 4; p++) begin
        v = (p == 0) ? 0 : (p == 1) ? 1023 : (ch * 149 + p * 211) % 1024;
        finish_cmpl(ch, v);
        rd(1, d); check("R6 global word", d, exp_gl(1, ch, v));
        rd(1, d); check("R6 global cleared", d, exp_gl(0, ch, v));
        rd(4 + ch, d); check("R2 R3 chan word", d, exp_ch(1, 0, v));
        rd(4 + ch, d); check("R3 done cleared", d, exp_ch(0, 0, v));
      end
    end
    finish_cmpl(1, 77);
    rd(5, d); check("R3 ch1", d, exp_ch(1, 0, 77));
    rd(1, d); check("R6 chan read keeps global", d, exp_gl(1, 1, 77));

    // R4 overrun
    finish_cmpl(2, 100); finish_cmpl(2, 200);
    rd(6, d); check("R4 no ovr single", d, exp_ch(1, 0, 200));
    wr(0, 9'h8);
    finish_cmpl(3, 300);
    rd(7, d); check("R4 burst single no ovr", d, exp_ch(1, 0, 300));
    finish_cmpl(3, 301); finish_cmpl(3, 302);
    rd(7, d); check("R4 burst ovr", d, exp_ch(1, 1, 302));
    rd(7, d); check("R4 ovr cleared", d, exp_ch(0, 0, 302));
    wr(0, 0);
    clear_all();

    // R5 set wins
    finish_cmpl(4, 400);
    @(negedge clk);
    done_vld = 1; done_chan = 3'd4; done_res = 10'd401;
    bus_sel = 1; bus_wr = 0; bus_addr = 4'd8;
    #1 check("R5 read returns old", bus_rdata, exp_ch(1, 0, 400));
    @(negedge clk);
    done_vld = 0; bus_sel = 0;
    rd(8, d); check("R5 flag kept", d, exp_ch(1, 0, 401));
    clear_all();

    // R7 interrupt
    for (int k = 0; k < 5; k++) begin
      wr(2, 9'(1 << k));
      finish_cmpl((k + 1) % 5, 5);
      check("R7 disabled ch", 32'(irq), 0);
      finish_cmpl(k, 6);
      check("R7 enabled ch", 32'(irq), 1);
      rd(4 + k, d);
      #1 check("R7 cleared", 32'(irq), 0);
      clear_all();
    end
    wr(2, 9'h100);
    finish_cmpl(0, 9);
    check("R7 global irq", 32'(irq), 1);
    rd(4, d);
    #1 check("R7 global held", 32'(irq), 1);
    rd(1, d);
    #1 check("R7 global cleared", 32'(irq), 0);

    // R10 ignored inputs
    wr(2, 9'h11F);
    finish_cmpl(5, 123);
    check("R10 ch5 no irq", 32'(irq), 0);
    finish_cmpl(7, 456);
    rd(1, d); check("R10 global untouched", d, exp_gl(0, 0, 9));
    rd(4, d); check("R10 ch0 untouched", d, exp_ch(0, 0, 9));
    finish_cmpl(0, 341); rd(4, d);
    wr(4, 9'h1FF);
    rd(4, d); check("R10 data write ignored", d, exp_ch(0, 0, 341));
    wr(2, 0);

    // R8 R9 trigger sweep
    for (int code = 2; code < 8; code++)
      for (int fall = 0; fall < 2; fall++)
        for (int line = 0; line < 6; line++)
          trig_trial(code, fall, 0, line, line == code - 2);
    for (int code = 0; code < 2; code++)
      for (int line = 0; line < 6; line++)
        trig_trial(code, 0, 0, line, 0);
    for (int code = 2; code < 8; code++)
      trig_trial(code, code % 2, 1, code - 2, 0);

    a = checks; b = failures;
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", a, b);
      $finish;
    end
  end
endmodule